// File: doc/BRIEF.md
# Nibble-Serial Firmware Bus Target

This block is the memory-side end of a 4-bit firmware bus that carries one framing strobe and a shared data nibble per clock. It watches the strobe and the nibble lane and recognises the start of a read or write. It compares a chip-select nibble against four strap inputs and collects a 28-bit address, most significant nibble first. A size nibble that must be zero follows. For a write it then takes the data byte, least significant nibble first. The bus is bidirectional, so the block has a plain input lane, an output lane and a registered output enable. The pad or the parent module joins these into a tri-state pin.

Each claimed cycle becomes one single-byte request on a valid/ready port towards an internal register or array model. A request is held stable while `req_ready` is low and leaves the port on the edge where valid and ready are both high. Reads answer on `rsp_valid`/`rsp_data`. This response has no ready, because the target always accepts it. The bus side fixes no latency for the answer: the target keeps sending wait-sync nibbles until the byte has arrived. Only one read is outstanding at a time. A write still waiting to be accepted is sent before a later read.

The framing strobe is active low. If it falls in the middle of a cycle, that cycle is dropped and the lane is released. If the nibble seen at that moment is a start code, a new cycle begins at once.

Top module: `fwb_target`

## Requirements
- R1: A cycle starts at a rising edge with `frame_n` low and `bus_in` equal to 4'b1101 (read) or 4'b1110 (write). Any other nibble with `frame_n` low starts nothing.
- R2: The nibble after the start is claimed only if it equals `id_strap`. Otherwise the rest of the cycle is ignored: `bus_oe` stays low and no request is made until the next start.
- R3: The next seven nibbles form `req_addr`, most significant nibble first.
- R4: The size nibble after the address must be 4'b0000. Any other value makes the cycle ignored as in R2.
- R5: Read reply, counted from the cycle after the size nibble:
  - one host turnaround cycle with `bus_oe` low;
  - then 4'b1111 driven;
  - then at least two cycles of 4'b0101 (exactly two when the byte is already back);
  - then 4'b0000;
  - then the data byte, low nibble first;
  - then 4'b1111;
  - then `bus_oe` low.
- R6: Write sequence:
  - the two nibbles after the size nibble are the write byte, low nibble first, and become `req_wdata` with `req_write`=1;
  - one host turnaround cycle follows;
  - the target then drives 4'b1111, then 4'b0000, then 4'b1111, then releases the lane.
- R7: A write request is formed as soon as its last data nibble is taken. A later abort does not cancel it.
- R8: `frame_n` sampled low in the middle of a claimed cycle forces `bus_oe` low in the next cycle. The cycle is dropped, and a read dropped before its size nibble makes no request. If the nibble sampled with `frame_n` low is a start code, a new cycle starts from it.
- R9: `req_valid`, `req_write`, `req_addr` and `req_wdata` hold steady while `req_valid` is high and `req_ready` is low. Requests leave in the order their cycles finished.
- R10: Wait-sync is extended until the read byte returns. The response to a read whose cycle was aborted is discarded, and the next read returns its own byte.
- R11: After reset `bus_oe` and `req_valid` are low. `bus_oe` is high only in target-owned cycles and is driven from a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low cycle framing strobe |
| bus_in | input | 4 | Nibble lane as seen from the pad |
| bus_out | output | 4 | Nibble driven by the target |
| bus_oe | output | 1 | Registered enable for bus_out |
| id_strap | input | 4 | Device select straps |
| req_valid | output | 1 | Internal request valid |
| req_ready | input | 1 | Internal side accepts the request |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | 28 | Byte address |
| req_wdata | output | 8 | Write byte |
| rsp_valid | input | 1 | Read byte valid (one cycle) |
| rsp_data | input | 8 | Read byte |

## Verification
Reads and writes are run with random addresses, bytes and straps against two internal-side behaviours. One answers at once, which pins the wait-sync count at exactly two. The other applies random back-pressure and latency, which tells a fixed wait count apart from one that tracks the response. Cycles with a mismatched select or a non-zero size show whether the target can be drawn onto the lane or into a request when it should stay silent. Aborts are placed in the address phase, in wait-sync and after write data, plus a restart that carries a start code. Together they separate cancelling, releasing and still issuing, and they show that a late response from an aborted read is never handed to the next one.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_SIZE,
    ST_WDAT,
    ST_TAR_H,
    ST_TAR_T,
    ST_WAIT,
    ST_RDY,
    ST_RDAT,
    ST_ACK,
    ST_END,
    ST_SKIP
  } fwb_state_e;

  localparam logic [3:0] NIB_GO_RD = 4'b1101;
  localparam logic [3:0] NIB_GO_WR = 4'b1110;
  localparam logic [3:0] NIB_TURN  = 4'b1111;
  localparam logic [3:0] NIB_WAIT  = 4'b0101;
  localparam logic [3:0] NIB_READY = 4'b0000;
  localparam logic [3:0] NIB_ONE_B = 4'b0000;

endpackage

// File: rtl/fwb_seq.sv
module fwb_seq
  import fwb_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int DATA_W   = 8,
  parameter int MIN_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        bus_in,
  input  logic [3:0]        id_strap,
  input  logic              rd_ok,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [3:0]        bus_out,
  output logic              bus_oe,
  output logic              rd_issue,
  output logic              wr_issue,
  output logic              abort,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [DATA_W-1:0] cyc_wdata
);

  localparam int ANIB  = ADDR_W / 4;
  localparam int DNIB  = DATA_W / 4;
  localparam int CMAX  = (ANIB > MIN_WAIT) ? ANIB : MIN_WAIT;
  localparam int CNT_W = $clog2(CMAX + DNIB + 1);

  fwb_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [3:0]        drv_nib;
  logic              drv_oe;
  logic              go_hit;

  assign go_hit    = !frame_n && (bus_in == NIB_GO_RD || bus_in == NIB_GO_WR);
  assign cyc_addr  = addr_q;
  assign cyc_wdata = {bus_in, wdat_q[DATA_W-1:4]};

  // next-state decode; a low strobe overrides every phase
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    wr_d     = wr_q;
    rd_issue = 1'b0;
    wr_issue = 1'b0;
    abort    = !frame_n && st_q != ST_IDLE && st_q != ST_SKIP;
    if (!frame_n) begin
      st_d  = go_hit ? ST_SEL : ST_IDLE;
      cnt_d = '0;
      if (go_hit) wr_d = (bus_in == NIB_GO_WR);
    end else begin
      case (st_q)
        ST_SEL: begin
          st_d  = (bus_in == id_strap) ? ST_ADDR : ST_SKIP;
          cnt_d = '0;
        end
        ST_ADDR: begin
          if (cnt_q == CNT_W'(ANIB - 1)) begin
            st_d  = ST_SIZE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_SIZE: begin
          if (bus_in != NIB_ONE_B) begin
            st_d = ST_SKIP;
          end else if (wr_q) begin
            st_d  = ST_WDAT;
            cnt_d = '0;
          end else begin
            st_d     = ST_TAR_H;
            rd_issue = 1'b1;
          end
        end
        ST_WDAT: begin
          if (cnt_q == CNT_W'(DNIB - 1)) begin
            st_d     = ST_TAR_H;
            wr_issue = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_TAR_H: st_d = ST_TAR_T;
        ST_TAR_T: begin
          st_d  = wr_q ? ST_ACK : ST_WAIT;
          cnt_d = '0;
        end
        ST_WAIT: begin
          if (cnt_q >= CNT_W'(MIN_WAIT - 1) && rd_ok) begin
            st_d  = ST_RDY;
            cnt_d = '0;
          end else if (cnt_q < CNT_W'(MIN_WAIT - 1)) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_RDY: begin
          st_d  = ST_RDAT;
          cnt_d = '0;
        end
        ST_RDAT: begin
          if (cnt_q == CNT_W'(DNIB - 1)) st_d = ST_END;
          else cnt_d = cnt_q + 1'b1;
        end
        ST_ACK:  st_d = ST_END;
        ST_END:  st_d = ST_IDLE;
        default: st_d = st_q;
      endcase
    end
  end

  // lane contents for the phase about to begin
  always_comb begin
    drv_oe  = 1'b1;
    drv_nib = NIB_TURN;
    case (st_d)
      ST_TAR_T, ST_END: drv_nib = NIB_TURN;
      ST_WAIT:          drv_nib = NIB_WAIT;
      ST_RDY, ST_ACK:   drv_nib = NIB_READY;
      ST_RDAT: begin
        for (int i = 0; i < DNIB; i++) begin
          if (cnt_d == CNT_W'(i)) drv_nib = rd_byte[4*i +: 4];
        end
      end
      default: drv_oe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      bus_out <= NIB_TURN;
      bus_oe  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      bus_out <= drv_nib;
      bus_oe  <= drv_oe;
      if (frame_n && st_q == ST_ADDR) addr_q <= {addr_q[ADDR_W-5:0], bus_in};
      if (frame_n && st_q == ST_WDAT) wdat_q <= cyc_wdata;
    end
  end

endmodule

// File: rtl/fwb_reqport.sv
module fwb_reqport #(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic              wr_issue,
  input  logic              abort,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_wdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rd_ok,
  output logic [DATA_W-1:0] rd_byte
);

  logic              need_rd, need_wr, rd_out, drop_q, have_q;
  logic [ADDR_W-1:0] rd_addr_h, wr_addr_h;
  logic [DATA_W-1:0] wr_data_h;
  logic              slot_free, load_wr, load_rd, rsp_take;

  assign slot_free = !req_valid || req_ready;
  assign load_wr   = slot_free && need_wr;
  assign load_rd   = slot_free && !need_wr && need_rd && !abort && !rd_out && !drop_q;
  assign rsp_take  = rsp_valid && (rd_out || drop_q);
  assign rd_ok     = have_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_rd   <= 1'b0;
      need_wr   <= 1'b0;
      rd_out    <= 1'b0;
      drop_q    <= 1'b0;
      have_q    <= 1'b0;
      rd_addr_h <= '0;
      wr_addr_h <= '0;
      wr_data_h <= '0;
      rd_byte   <= '0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (load_wr) begin
        req_valid <= 1'b1;
        req_write <= 1'b1;
        req_addr  <= wr_addr_h;
        req_wdata <= wr_data_h;
        need_wr   <= 1'b0;
      end else if (load_rd) begin
        req_valid <= 1'b1;
        req_write <= 1'b0;
        req_addr  <= rd_addr_h;
        req_wdata <= '0;
        need_rd   <= 1'b0;
        rd_out    <= 1'b1;
      end
      if (abort) need_rd <= 1'b0;
      if (rd_issue) begin
        need_rd   <= 1'b1;
        rd_addr_h <= cyc_addr;
        have_q    <= 1'b0;
      end
      if (wr_issue) begin
        need_wr   <= 1'b1;
        wr_addr_h <= cyc_addr;
        wr_data_h <= cyc_wdata;
      end
      if (rsp_take) begin
        rd_out <= 1'b0;
        if (drop_q) begin
          drop_q <= 1'b0;
        end else begin
          have_q  <= 1'b1;
          rd_byte <= rsp_data;
        end
      end else if (abort && rd_out) begin
        rd_out <= 1'b0;
        drop_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fwb_target.sv
module fwb_target #(
  parameter int ADDR_W   = 28,
  parameter int DATA_W   = 8,
  parameter int MIN_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        bus_in,
  output logic [3:0]        bus_out,
  output logic              bus_oe,
  input  logic [3:0]        id_strap,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data
);

  logic              rd_issue, wr_issue, abort, rd_ok;
  logic [ADDR_W-1:0] cyc_addr;
  logic [DATA_W-1:0] cyc_wdata, rd_byte;

  fwb_seq #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MIN_WAIT(MIN_WAIT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .bus_in   (bus_in),
    .id_strap (id_strap),
    .rd_ok    (rd_ok),
    .rd_byte  (rd_byte),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .rd_issue (rd_issue),
    .wr_issue (wr_issue),
    .abort    (abort),
    .cyc_addr (cyc_addr),
    .cyc_wdata(cyc_wdata)
  );

  fwb_reqport #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_issue (rd_issue),
    .wr_issue (wr_issue),
    .abort    (abort),
    .cyc_addr (cyc_addr),
    .cyc_wdata(cyc_wdata),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .rd_ok    (rd_ok),
    .rd_byte  (rd_byte)
  );

endmodule

// File: rtl/fwb_target_chk.sv
module fwb_target_chk #(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_n,
  input logic [3:0]        bus_out,
  input logic              bus_oe,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else armed <= 1'b1;
  end

  // R5: taking the lane always begins with a turnaround nibble
  p_take_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $rose(bus_oe) |-> bus_out == 4'b1111);

  // R5: the lane is let go only after a turnaround nibble or an abort
  p_release_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $fell(bus_oe) |-> ($past(bus_out) == 4'b1111) || !$past(frame_n));

  // R8: a low strobe mid-cycle leaves the lane undriven in the next cycle
  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !frame_n |=> !bus_oe);

  // R9: a stalled request does not move
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_write)
      && $stable(req_addr) && $stable(req_wdata));

  // R10: wait-sync is never left by dropping the lane
  p_wait_owned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe && bus_out == 4'b0101 && frame_n |=> bus_oe);

endmodule

bind fwb_target fwb_target_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_n  (frame_n),
  .bus_out  (bus_out),
  .bus_oe   (bus_oe),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata)
);

// File: tb/test_fwb_target.sv
module test_fwb_target;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  bus_in = 4'hF;
  logic [3:0]  bus_out;
  logic        bus_oe;
  logic [3:0]  id_strap = 4'h0;
  logic        req_valid, req_write;
  logic        req_ready = 1'b0;
  logic [27:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_data = 8'h00;

  int errors = 0;
  int checks = 0;
  int n_req = 0;
  int lat_cnt = 0;
  bit g_rand = 1'b0;
  int g_lat = 1;
  bit g_lat_rand = 1'b0;
  logic [7:0]  pend_data;
  bit          log_w [0:63];
  logic [27:0] log_a [0:63];
  logic [7:0]  log_d [0:63];

  always #5 clk = ~clk;

  fwb_target i_fwb_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .id_strap(id_strap),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] exp_data(input logic [27:0] a);
    return a[7:0] ^ a[15:8] ^ a[27:20] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // internal-side model: ready and response driven away from the edge
  always @(negedge clk) begin
    if (!rst_n) begin
      req_ready = 1'b0;
      rsp_valid = 1'b0;
      lat_cnt = 0;
    end else begin
      rsp_valid = 1'b0;
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          rsp_valid = 1'b1;
          rsp_data = pend_data;
        end
      end
      req_ready = g_rand ? 1'($urandom % 2) : 1'b1;
      if (req_valid && req_ready) begin
        log_w[n_req % 64] = req_write;
        log_a[n_req % 64] = req_addr;
        log_d[n_req % 64] = req_wdata;
        n_req++;
        if (!req_write) begin
          lat_cnt = g_lat_rand ? 1 + int'($urandom % 6) : g_lat;
          pend_data = exp_data(req_addr);
        end
      end
    end
  end

  task automatic step(input logic f, input logic [3:0] n,
                      output logic oe, output logic [3:0] o);
    @(negedge clk);
    oe = bus_oe;
    o = bus_out;
    frame_n = f;
    bus_in = n;
  endtask

  task automatic settle();
    logic oe;
    logic [3:0] o;
    for (int k = 0; k < 100 && (req_valid || lat_cnt > 0); k++) step(1'b1, 4'hF, oe, o);
    for (int k = 0; k < 3; k++) step(1'b1, 4'hF, oe, o);
  endtask

  task automatic host_head(input logic [3:0] go, input logic [3:0] id,
                           input logic [27:0] a, input logic [3:0] sz, inout bit bad);
    logic oe;
    logic [3:0] o;
    step(1'b0, go, oe, o);  bad |= oe;
    step(1'b1, id, oe, o);  bad |= oe;
    for (int i = 0; i < 7; i++) begin
      step(1'b1, a[4*(6-i) +: 4], oe, o);
      bad |= oe;
    end
    step(1'b1, sz, oe, o);  bad |= oe;
  endtask

  task automatic do_read(input logic [3:0] id, input logic [27:0] a, input logic [3:0] sz,
                         input int abort_at, input bit claim, input bit exact, input bit do_settle);
    logic oe;
    logic [3:0] o;
    logic [4:0] sq [0:47];
    bit bad = 1'b0;
    bit ok;
    int p, waits, n0;
    logic [7:0] got;
    n0 = n_req;
    host_head(4'b1101, id, a, sz, bad);
    step(1'b1, 4'hF, oe, o);  bad |= oe;
    chk(!bad, "R11", "read host cycles left undriven", {31'd0, bad}, 0);
    for (int k = 0; k < 48; k++) begin
      step((k == abort_at) ? 1'b0 : 1'b1, 4'hF, oe, o);
      sq[k] = {oe, o};
    end
    if (!claim) begin
      ok = 1'b1;
      for (int k = 0; k < 48; k++) ok &= !sq[k][4];
      chk(ok, "R2", "unclaimed read keeps lane off", {31'd0, ok}, 1);
      if (do_settle) settle();
      chk(n_req == n0, "R4", "unclaimed read makes no request", n_req - n0, 0);
    end else if (abort_at >= 0) begin
      ok = 1'b1;
      for (int k = abort_at + 1; k < 48; k++) ok &= !sq[k][4];
      chk(sq[abort_at][4] && ok, "R8", "abort in wait releases lane next cycle", {27'd0, sq[abort_at]}, 5'h15);
      if (do_settle) settle();
    end else begin
      ok = (sq[0] == 5'h1F);
      p = 1;
      waits = 0;
      while (p < 40 && sq[p] == 5'h15) begin
        waits++;
        p++;
      end
      ok &= (sq[p] == 5'h10) && sq[p+1][4] && sq[p+2][4] && (sq[p+3] == 5'h1F);
      for (int k = p + 4; k < 48; k++) ok &= !sq[k][4];
      got = {sq[p+2][3:0], sq[p+1][3:0]};
      chk(ok, "R5", "read reply shape", {27'd0, sq[p]}, 5'h10);
      if (exact) chk(waits == 2, "R5", "wait-sync count", waits, 2);
      else chk(waits >= 2 && waits < 40, "R10", "stretched wait-sync count", waits, 2);
      chk(got == exp_data(a), "R10", "read byte low nibble first", got, exp_data(a));
      if (do_settle) settle();
      chk(n_req == n0 + 1 && !log_w[n0 % 64] && log_a[n0 % 64] == a, "R3",
          "read request address", log_a[n0 % 64], a);
    end
  endtask

  task automatic do_write(input logic [3:0] id, input logic [27:0] a, input logic [7:0] d,
                          input int abort_at, input bit do_settle);
    logic oe;
    logic [3:0] o;
    logic [4:0] sq [0:15];
    bit bad = 1'b0;
    bit ok;
    int n0;
    n0 = n_req;
    host_head(4'b1110, id, a, 4'b0000, bad);
    step(1'b1, d[3:0], oe, o);  bad |= oe;
    step(1'b1, d[7:4], oe, o);  bad |= oe;
    step(1'b1, 4'hF, oe, o);    bad |= oe;
    chk(!bad, "R11", "write host cycles left undriven", {31'd0, bad}, 0);
    for (int k = 0; k < 16; k++) begin
      step((k == abort_at) ? 1'b0 : 1'b1, 4'hF, oe, o);
      sq[k] = {oe, o};
    end
    if (abort_at < 0) begin
      ok = (sq[0] == 5'h1F) && (sq[1] == 5'h10) && (sq[2] == 5'h1F);
      for (int k = 3; k < 16; k++) ok &= !sq[k][4];
      chk(ok, "R6", "write reply shape", {27'd0, sq[1]}, 5'h10);
    end else begin
      chk(!sq[abort_at + 1][4], "R8", "abort after write data releases lane",
          {31'd0, sq[abort_at + 1][4]}, 0);
    end
    if (do_settle) begin
      settle();
      chk(n_req == n0 + 1, "R7", "write request count", n_req - n0, 1);
      chk(log_w[n0 % 64] && log_a[n0 % 64] == a && log_d[n0 % 64] == d, "R6",
          "write request byte", {log_a[n0 % 64][23:0], log_d[n0 % 64]}, {a[23:0], d});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic oe;
    logic [3:0] o;
    bit ok;
    int n0;
    void'($urandom(32'd1357));
    id_strap = 4'h3;
    repeat (3) @(negedge clk);
    chk(!bus_oe && !req_valid, "R11", "reset state", {30'd0, bus_oe, req_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed, immediate internal side
    do_read(4'h3, 28'h0000000, 4'h0, -1, 1'b1, 1'b1, 1'b1);
    do_read(4'h3, 28'hFFFFFFF, 4'h0, -1, 1'b1, 1'b1, 1'b1);
    do_write(4'h3, 28'h1234567, 8'hA5, -1, 1'b1);
    do_read(4'h7, 28'h0ABCDEF, 4'h0, -1, 1'b0, 1'b0, 1'b1);   // R2 mismatch
    do_read(4'h3, 28'h0ABCDEF, 4'h1, -1, 1'b0, 1'b0, 1'b1);   // R4 bad size

    // R1: strobe low with a non-start nibble, then address-like traffic
    n0 = n_req;
    ok = 1'b1;
    step(1'b0, 4'h0, oe, o);
    for (int k = 0; k < 20; k++) begin
      step(1'b1, (k == 0) ? 4'h3 : 4'h0, oe, o);
      ok &= !oe;
    end
    settle();
    chk(ok && n_req == n0, "R1", "non-start nibble starts nothing", n_req - n0, 0);

    // R8: abort in the address phase, no request
    n0 = n_req;
    ok = 1'b1;
    step(1'b0, 4'b1101, oe, o);
    step(1'b1, 4'h3, oe, o);
    step(1'b1, 4'h0, oe, o);
    step(1'b0, 4'hF, oe, o);
    for (int k = 0; k < 20; k++) begin
      step(1'b1, 4'hF, oe, o);
      ok &= !oe;
    end
    settle();
    chk(ok && n_req == n0, "R8", "address-phase abort makes no request", n_req - n0, 0);

    // R8: restart with a start code mid-cycle
    step(1'b0, 4'b1110, oe, o);
    step(1'b1, 4'h3, oe, o);
    step(1'b1, 4'h1, oe, o);
    do_read(4'h3, 28'h5566778, 4'h0, -1, 1'b1, 1'b1, 1'b1);

    // R7: abort during the ack nibble still delivers the write
    do_write(4'h3, 28'h0C0FFEE, 8'h3C, 1, 1'b1);

    // R10: aborted read with slow answer, its byte must not leak into the next read
    g_lat = 12;
    do_read(4'h3, 28'h0000111, 4'h0, 2, 1'b1, 1'b0, 1'b0);
    g_lat = 1;
    do_read(4'h3, 28'h0000222, 4'h0, -1, 1'b1, 1'b0, 1'b1);

    // R9: write still stalled when the following read issues
    g_rand = 1'b1;
    n0 = n_req;
    do_write(4'h3, 28'h0777777, 8'h81, -1, 1'b0);
    do_read(4'h3, 28'h0888888, 4'h0, -1, 1'b1, 1'b0, 1'b1);
    chk(log_w[n0 % 64] && log_a[n0 % 64] == 28'h0777777 && log_d[n0 % 64] == 8'h81,
        "R9", "write leaves before later read", log_a[n0 % 64], 28'h0777777);

    // constrained random mix
    for (int t = 0; t < 30; t++) begin
      logic [27:0] a;
      logic [7:0] d;
      bit fast;
      a = 28'($urandom);
      d = 8'($urandom);
      fast = 1'($urandom % 2);
      g_rand = !fast;
      g_lat_rand = !fast;
      id_strap = 4'($urandom);
      if ($urandom % 5 == 0) do_read(id_strap ^ 4'h8, a, 4'h0, -1, 1'b0, 1'b0, 1'b1);
      else if ($urandom % 2 == 0) do_write(id_strap, a, d, -1, 1'b1);
      else do_read(id_strap, a, 4'h0, -1, 1'b1, fast, 1'b1);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule